// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the host bus of a dot-matrix display controller. Each transfer carries a byte and two tags: whether the byte is a command or display data, and whether the host wants to read or write. Command bytes are decoded by their upper bits into single-byte and two-byte commands. These commands update a set of configuration registers and the page/column pointers into display memory. Data transfers become one-cycle strobes towards the display RAM and then move the column pointer.

A read-modify-write mode lets the host read a byte, change it and write it back without setting the address again. In this mode only writes move the column, and leaving the mode returns the column to where it was when the mode began. All outputs are registered. A transfer presented in one cycle shows at the outputs after the next rising clock edge.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset the display is off, start line, page, column, flags, power mode, resistor ratio and static mode are zero, volume is 32, read-modify-write is inactive, and the status byte is {0, segment-reverse, display-on, rmw-active, 4'b0000} (bit 6 = segment reverse, bit 5 = display on, bit 4 = rmw active).
- R2: Command AFh sets display_on and AEh clears it.
- R3: Commands 40h to 7Fh load start_line from bits 5:0.
- R4: Commands B0h to BFh load page_addr from bits 3:0.
- R5: Command 1xh loads column bits 7:4 from x, and 0xh loads column bits 3:0 from x, each leaving the other nibble unchanged.
- R6: Bit 0 of A0h/A1h sets seg_reverse, of A6h/A7h sets invert, of A4h/A5h sets all_on, and of A2h/A3h sets bias_alt. Bit 3 of Cxh sets com_reverse. 28h to 2Fh load power_mode from bits 2:0, and 20h to 27h load resistor_ratio from bits 2:0.
- R7: A data write gives a one-cycle ram_we with the page, the column before the access and the byte. A data read gives a one-cycle ram_re. Outside read-modify-write, either access advances the column by one.
- R8: The column stops at 131. An access at column 131 uses column 131 and leaves the column there.
- R9: E0h enters read-modify-write and records the column. In this mode reads leave the column unchanged and writes advance it. EEh leaves the mode and restores the recorded column. E0h inside the mode and EEh outside it have no effect.
- R10: After 81h, the next command byte is taken as an operand and loads volume from bits 5:0. After ACh or ADh, static_on takes bit 0 of that opcode, and the next command byte loads static_mode from bits 1:0. An operand byte is never decoded as a command.
- R11: E2h returns every register and pointer to its reset value. E3h changes nothing.
- R12: Unknown command bytes (F0h to FFh, 30h to 3Fh, 80h, 82h to 9Fh, A8h to ABh, D0h to DFh, other Exh) change nothing, and neither does a read with the command tag.
- R13: Reset cancels a pending operand, so the first command byte after reset is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A transfer is present this cycle |
| bus_is_data | input | 1 | 1 = display data, 0 = command |
| bus_read | input | 1 | 1 = read transfer, 0 = write |
| bus_byte | input | 8 | Command or write data byte |
| display_on | output | 1 | Panel enable |
| start_line | output | 6 | Display line mapped to the first common |
| page_addr | output | 4 | Current RAM page |
| column_addr | output | 8 | Current RAM column |
| seg_reverse | output | 1 | Segment order reversed |
| invert | output | 1 | Reverse video |
| all_on | output | 1 | Force every pixel on |
| bias_alt | output | 1 | Alternate bias ratio |
| com_reverse | output | 1 | Common scan reversed |
| power_mode | output | 3 | Power circuit enables |
| resistor_ratio | output | 3 | Regulator resistor ratio |
| volume | output | 6 | Electronic volume |
| static_on | output | 1 | Static indicator enable |
| static_mode | output | 2 | Static indicator blink mode |
| rmw_active | output | 1 | Read-modify-write mode active |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_page | output | 4 | Page of the current access |
| ram_col | output | 8 | Column of the current access |
| ram_wdata | output | 8 | Write data of the current access |
| status | output | 8 | Status byte |

## Verification
A decoder that lost track of a pending operand would show up on the next command byte: the wrong register would change, visible one cycle later. A column pointer that advanced wrongly would show on ram_col at the next strobe, and after EEh it would show at once as a wrong restored column_addr. The scoreboard compares every RAM strobe in order with the page, column and byte predicted from the requirements. A full register snapshot after each stimulus group catches any stray write to a configuration field within one transfer.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  typedef enum logic [4:0] {
    OP_NONE, OP_DISP, OP_START, OP_PAGE, OP_COL_HI, OP_COL_LO,
    OP_SEG, OP_INV, OP_ALLON, OP_BIAS, OP_RMW_ON, OP_RMW_OFF,
    OP_RESET, OP_VOL, OP_STATIC, OP_COM, OP_POWER, OP_RATIO
  } op_e;

  typedef enum logic [1:0] {
    PEND_NONE, PEND_VOL, PEND_STATIC
  } pend_e;

  // Opcode families are keyed on the upper bits; the rest carry arguments.
  function automatic op_e classify(input logic [7:0] b);
    op_e r;
    casez (b)
      8'b0000_????: r = OP_COL_LO;
      8'b0001_????: r = OP_COL_HI;
      8'b0010_0???: r = OP_RATIO;
      8'b0010_1???: r = OP_POWER;
      8'b01??_????: r = OP_START;
      8'b1000_0001: r = OP_VOL;
      8'b1010_000?: r = OP_SEG;
      8'b1010_001?: r = OP_BIAS;
      8'b1010_010?: r = OP_ALLON;
      8'b1010_011?: r = OP_INV;
      8'b1010_110?: r = OP_STATIC;
      8'b1010_111?: r = OP_DISP;
      8'b1011_????: r = OP_PAGE;
      8'b1100_????: r = OP_COM;
      8'b1110_0000: r = OP_RMW_ON;
      8'b1110_1110: r = OP_RMW_OFF;
      8'b1110_0010: r = OP_RESET;
      default:      r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcd_op_classify.sv
module lcd_op_classify
  import lcd_cmd_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output op_e        op
);
  always_comb begin
    op = cmd_valid ? classify(cmd_byte) : OP_NONE;
  end
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_cmd_pkg::*;
#(
  parameter int LINE_W    = 6,
  parameter int VOL_W     = 6,
  parameter int VOL_RESET = 32,
  parameter int PWR_W     = 3,
  parameter int RATIO_W   = 3,
  parameter int SMODE_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  op_e                op,
  input  logic [LINE_W-1:0]  arg,
  output logic               pending,
  output logic               display_on,
  output logic [LINE_W-1:0]  start_line,
  output logic               seg_reverse,
  output logic               invert,
  output logic               all_on,
  output logic               bias_alt,
  output logic               com_reverse,
  output logic [PWR_W-1:0]   power_mode,
  output logic [RATIO_W-1:0] resistor_ratio,
  output logic [VOL_W-1:0]   volume,
  output logic               static_on,
  output logic [SMODE_W-1:0] static_mode
);
  pend_e pend_q;
  logic  soft_rst;

  assign pending  = (pend_q != PEND_NONE);
  assign soft_rst = cmd_valid && !pending && (op == OP_RESET);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      pend_q         <= PEND_NONE;
      display_on     <= 1'b0;
      start_line     <= '0;
      seg_reverse    <= 1'b0;
      invert         <= 1'b0;
      all_on         <= 1'b0;
      bias_alt       <= 1'b0;
      com_reverse    <= 1'b0;
      power_mode     <= '0;
      resistor_ratio <= '0;
      volume         <= VOL_W'(VOL_RESET);
      static_on      <= 1'b0;
      static_mode    <= '0;
    end else if (cmd_valid) begin
      if (pending) begin
        // second byte of a two-byte command: operand only
        if (pend_q == PEND_VOL) volume <= arg[VOL_W-1:0];
        else                    static_mode <= arg[SMODE_W-1:0];
        pend_q <= PEND_NONE;
      end else begin
        case (op)
          OP_DISP:   display_on     <= arg[0];
          OP_START:  start_line     <= arg;
          OP_SEG:    seg_reverse    <= arg[0];
          OP_INV:    invert         <= arg[0];
          OP_ALLON:  all_on         <= arg[0];
          OP_BIAS:   bias_alt       <= arg[0];
          OP_COM:    com_reverse    <= arg[3];
          OP_POWER:  power_mode     <= arg[PWR_W-1:0];
          OP_RATIO:  resistor_ratio <= arg[RATIO_W-1:0];
          OP_VOL:    pend_q         <= PEND_VOL;
          OP_STATIC: begin
            static_on <= arg[0];
            pend_q    <= PEND_STATIC;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_addr_ctrl.sv
module lcd_addr_ctrl
  import lcd_cmd_pkg::*;
#(
  parameter int PAGE_W   = 4,
  parameter int COL_W    = 8,
  parameter int NUM_COLS = 132,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [3:0]        nib,
  input  logic              data_valid,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] data_byte,
  output logic [PAGE_W-1:0] page_addr,
  output logic [COL_W-1:0]  column_addr,
  output logic              rmw_active,
  output logic              ram_we,
  output logic              ram_re,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_col,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int COL_LAST = NUM_COLS - 1;
  localparam int HI_W     = COL_W - 4;

  logic [COL_W-1:0] saved_col;
  logic             at_last;
  logic             advance;

  assign at_last = (column_addr >= COL_W'(COL_LAST));
  assign advance = data_valid && !(rmw_active && data_rd) && !at_last;

  always_ff @(posedge clk) begin
    if (rst || op == OP_RESET) begin
      page_addr   <= '0;
      column_addr <= '0;
      saved_col   <= '0;
      rmw_active  <= 1'b0;
      ram_we      <= 1'b0;
      ram_re      <= 1'b0;
      ram_page    <= '0;
      ram_col     <= '0;
      ram_wdata   <= '0;
    end else begin
      ram_we <= data_valid && !data_rd;
      ram_re <= data_valid && data_rd;
      if (data_valid) begin
        ram_page <= page_addr;
        ram_col  <= column_addr;
        if (!data_rd) ram_wdata <= data_byte;
      end
      if (advance) column_addr <= column_addr + COL_W'(1);
      case (op)
        OP_PAGE:   page_addr <= nib[PAGE_W-1:0];
        OP_COL_HI: column_addr <= {nib[HI_W-1:0], column_addr[3:0]};
        OP_COL_LO: column_addr <= {column_addr[COL_W-1:4], nib};
        OP_RMW_ON: if (!rmw_active) begin
          rmw_active <= 1'b1;
          saved_col  <= column_addr;
        end
        OP_RMW_OFF: if (rmw_active) begin
          rmw_active  <= 1'b0;
          column_addr <= saved_col;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
  import lcd_cmd_pkg::*;
#(
  parameter int LINE_W    = 6,
  parameter int PAGE_W    = 4,
  parameter int COL_W     = 8,
  parameter int NUM_COLS  = 132,
  parameter int VOL_W     = 6,
  parameter int VOL_RESET = 32,
  parameter int PWR_W     = 3,
  parameter int RATIO_W   = 3,
  parameter int SMODE_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_is_data,
  input  logic               bus_read,
  input  logic [7:0]         bus_byte,
  output logic               display_on,
  output logic [LINE_W-1:0]  start_line,
  output logic [PAGE_W-1:0]  page_addr,
  output logic [COL_W-1:0]   column_addr,
  output logic               seg_reverse,
  output logic               invert,
  output logic               all_on,
  output logic               bias_alt,
  output logic               com_reverse,
  output logic [PWR_W-1:0]   power_mode,
  output logic [RATIO_W-1:0] resistor_ratio,
  output logic [VOL_W-1:0]   volume,
  output logic               static_on,
  output logic [SMODE_W-1:0] static_mode,
  output logic               rmw_active,
  output logic               ram_we,
  output logic               ram_re,
  output logic [PAGE_W-1:0]  ram_page,
  output logic [COL_W-1:0]   ram_col,
  output logic [7:0]         ram_wdata,
  output logic [7:0]         status
);
  logic cmd_valid, data_valid, pending;
  op_e  op_raw, op_eff;

  assign cmd_valid  = bus_valid && !bus_is_data && !bus_read;
  assign data_valid = bus_valid && bus_is_data;
  assign op_eff     = pending ? OP_NONE : op_raw;

  lcd_op_classify u_cls (
    .cmd_valid (cmd_valid),
    .cmd_byte  (bus_byte),
    .op        (op_raw)
  );

  lcd_cfg_regs #(
    .LINE_W(LINE_W), .VOL_W(VOL_W), .VOL_RESET(VOL_RESET),
    .PWR_W(PWR_W), .RATIO_W(RATIO_W), .SMODE_W(SMODE_W)
  ) u_cfg (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .op             (op_raw),
    .arg            (bus_byte[LINE_W-1:0]),
    .pending        (pending),
    .display_on     (display_on),
    .start_line     (start_line),
    .seg_reverse    (seg_reverse),
    .invert         (invert),
    .all_on         (all_on),
    .bias_alt       (bias_alt),
    .com_reverse    (com_reverse),
    .power_mode     (power_mode),
    .resistor_ratio (resistor_ratio),
    .volume         (volume),
    .static_on      (static_on),
    .static_mode    (static_mode)
  );

  lcd_addr_ctrl #(
    .PAGE_W(PAGE_W), .COL_W(COL_W), .NUM_COLS(NUM_COLS), .DATA_W(8)
  ) u_addr (
    .clk         (clk),
    .rst         (rst),
    .op          (op_eff),
    .nib         (bus_byte[3:0]),
    .data_valid  (data_valid),
    .data_rd     (bus_read),
    .data_byte   (bus_byte),
    .page_addr   (page_addr),
    .column_addr (column_addr),
    .rmw_active  (rmw_active),
    .ram_we      (ram_we),
    .ram_re      (ram_re),
    .ram_page    (ram_page),
    .ram_col     (ram_col),
    .ram_wdata   (ram_wdata)
  );

  assign status = {1'b0, seg_reverse, display_on, rmw_active, 4'b0000};
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk #(
  parameter int PAGE_W   = 4,
  parameter int COL_W    = 8,
  parameter int NUM_COLS = 132
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_is_data,
  input logic              bus_read,
  input logic [3:0]        bus_byte_hi,
  input logic              display_on,
  input logic [PAGE_W-1:0] page_addr,
  input logic [COL_W-1:0]  column_addr,
  input logic              rmw_active,
  input logic              ram_we,
  input logic              ram_re
);
  localparam logic [COL_W-1:0] LAST = COL_W'(NUM_COLS - 1);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  assert_we_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we) |-> $past(bus_valid && bus_is_data && !bus_read));

  assert_write_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_is_data && !bus_read && column_addr < LAST)
      |=> column_addr == $past(column_addr) + COL_W'(1));

  assert_col_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_is_data && column_addr == LAST) |=> column_addr == LAST);

  assert_rmw_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_is_data && bus_read && rmw_active) |=> $stable(column_addr));

  assert_test_range_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_is_data && bus_byte_hi == 4'hF)
      |=> ($stable(display_on) && $stable(page_addr)
           && $stable(column_addr) && $stable(rmw_active)));
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(
  .PAGE_W(PAGE_W), .COL_W(COL_W), .NUM_COLS(NUM_COLS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_is_data (bus_is_data),
  .bus_read    (bus_read),
  .bus_byte_hi (bus_byte[7:4]),
  .display_on  (display_on),
  .page_addr   (page_addr),
  .column_addr (column_addr),
  .rmw_active  (rmw_active),
  .ram_we      (ram_we),
  .ram_re      (ram_re)
);

// File: tb/tb_lcd_cmd_decoder.sv
module tb_lcd_cmd_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_is_data = 1'b0, bus_read = 1'b0;
  logic [7:0] bus_byte = 8'h00;

  logic display_on, seg_reverse, invert, all_on, bias_alt, com_reverse;
  logic static_on, rmw_active, ram_we, ram_re;
  logic [5:0] start_line, volume;
  logic [3:0] page_addr, ram_page;
  logic [7:0] column_addr, ram_col, ram_wdata, status;
  logic [2:0] power_mode, resistor_ratio;
  logic [1:0] static_mode;

  always #10 clk = ~clk;

  lcd_cmd_decoder dut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model, built from the requirements
  bit m_disp, m_seg, m_inv, m_all, m_bias, m_com, m_st, m_rmw;
  logic [5:0] m_start, m_vol;
  logic [3:0] m_page;
  logic [7:0] m_col, m_saved;
  logic [2:0] m_pwr, m_ratio;
  logic [1:0] m_smode;
  int m_pend;

  logic [21:0] exp_q[$];

  task automatic model_reset();
    {m_disp, m_seg, m_inv, m_all, m_bias, m_com, m_st, m_rmw} = '0;
    m_start = 0; m_vol = 6'd32; m_page = 0; m_col = 0; m_saved = 0;
    m_pwr = 0; m_ratio = 0; m_smode = 0; m_pend = 0;
  endtask

  function automatic logic [47:0] snap_dut();
    return {display_on, start_line, page_addr, column_addr, seg_reverse, invert,
            all_on, bias_alt, com_reverse, power_mode, resistor_ratio, volume,
            static_on, static_mode, rmw_active, status};
  endfunction

  function automatic logic [47:0] snap_model();
    return {m_disp, m_start, m_page, m_col, m_seg, m_inv, m_all, m_bias, m_com,
            m_pwr, m_ratio, m_vol, m_st, m_smode, m_rmw,
            {1'b0, m_seg, m_disp, m_rmw, 4'b0000}};
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    check(tag, snap_dut(), snap_model());
  endtask

  task automatic drive(bit dc, bit rd, logic [7:0] b);
    @(negedge clk);
    bus_valid = 1; bus_is_data = dc; bus_read = rd; bus_byte = b;
    @(negedge clk);
    bus_valid = 0; bus_is_data = 0; bus_read = 0;
  endtask

  task automatic send_cmd(logic [7:0] b);
    if (m_pend == 1) begin m_vol = b[5:0]; m_pend = 0; end
    else if (m_pend == 2) begin m_smode = b[1:0]; m_pend = 0; end
    else begin
      casez (b)
        8'b0000_????: m_col[3:0] = b[3:0];
        8'b0001_????: m_col[7:4] = b[3:0];
        8'b0010_0???: m_ratio = b[2:0];
        8'b0010_1???: m_pwr = b[2:0];
        8'b01??_????: m_start = b[5:0];
        8'h81:        m_pend = 1;
        8'b1010_000?: m_seg = b[0];
        8'b1010_001?: m_bias = b[0];
        8'b1010_010?: m_all = b[0];
        8'b1010_011?: m_inv = b[0];
        8'b1010_110?: begin m_st = b[0]; m_pend = 2; end
        8'b1010_111?: m_disp = b[0];
        8'b1011_????: m_page = b[3:0];
        8'b1100_????: m_com = b[3];
        8'hE0: if (!m_rmw) begin m_rmw = 1; m_saved = m_col; end
        8'hEE: if (m_rmw) begin m_rmw = 0; m_col = m_saved; end
        8'hE2: model_reset();
        default: ;
      endcase
    end
    drive(0, 0, b);
  endtask

  task automatic send_data(bit rd, logic [7:0] b);
    exp_q.push_back({~rd, rd, m_page, m_col, rd ? 8'h00 : b});
    if (!(m_rmw && rd) && m_col < 8'd131) m_col++;
    drive(1, rd, b);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  // monitor: pops expected RAM strobes in order
  always @(negedge clk) begin
    if (!rst && (ram_we || ram_re)) begin
      logic [21:0] e;
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7: unexpected strobe we=%b re=%b col=%0d expected none",
                 ram_we, ram_re, ram_col);
      end else begin
        e = exp_q.pop_front();
        if ({ram_we, ram_re, ram_page, ram_col, ram_we ? ram_wdata : 8'h00} !== e) begin
          fails++;
          $display("FAIL R7/R8/R9 strobe: actual %h expected %h",
                   {ram_we, ram_re, ram_page, ram_col, ram_we ? ram_wdata : 8'h00}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state("R1 reset state");

    send_cmd(8'hAF); check_state("R2 display on");
    send_cmd(8'hAE); check_state("R2 display off");
    send_cmd(8'hAF);

    send_cmd(8'h7F); check_state("R3 start line 63");
    send_cmd(8'h45); check_state("R3 start line 5");

    send_cmd(8'hB7); check_state("R4 page 7");

    send_cmd(8'h15); send_cmd(8'h0A); check_state("R5 column 5Ah");
    send_cmd(8'h03); check_state("R5 low nibble only");

    send_cmd(8'hA1); send_cmd(8'hA7); send_cmd(8'hA5); send_cmd(8'hA3);
    send_cmd(8'hC8); send_cmd(8'h2F); send_cmd(8'h25);
    check_state("R6 flags set");
    send_cmd(8'hA0); send_cmd(8'hA6); send_cmd(8'hC7); send_cmd(8'h2A);
    check_state("R6 flags partly cleared");

    send_cmd(8'h10); send_cmd(8'h04);
    send_data(0, 8'h3C); send_data(0, 8'hC3); send_data(1, 8'h00);
    check_state("R7 column after two writes and a read");

    send_cmd(8'h18); send_cmd(8'h02);
    send_data(0, 8'h11); send_data(0, 8'h22); send_data(1, 8'h00);
    check_state("R8 column saturated at 131");

    send_cmd(8'h10); send_cmd(8'h0A);
    send_cmd(8'hE0); check_state("R9 rmw entered");
    send_data(1, 8'h00); check_state("R9 read holds column");
    send_data(0, 8'h55); send_data(1, 8'h00); send_data(0, 8'h66);
    send_cmd(8'hE0); check_state("R9 second E0h ignored");
    send_cmd(8'hEE); check_state("R9 column restored to 10");
    send_cmd(8'hEE); check_state("R9 EEh outside mode ignored");

    send_cmd(8'h81); send_cmd(8'hAE); check_state("R10 volume operand not decoded");
    send_cmd(8'hAD); send_cmd(8'h02); check_state("R10 static on mode 2");
    send_cmd(8'hAC); send_cmd(8'hF3); check_state("R10 static off mode 3");

    send_cmd(8'hF0); send_cmd(8'hFF); send_cmd(8'h35); send_cmd(8'h90);
    send_cmd(8'hE5); send_cmd(8'hA9); send_cmd(8'hD4);
    check_state("R12 unknown opcodes ignored");
    drive(0, 1, 8'hAE); check_state("R12 command-tag read ignored");

    send_cmd(8'hE3); check_state("R11 E3h no change");
    send_cmd(8'hE2); check_state("R11 E2h defaults");

    send_cmd(8'h81);
    do_reset();
    send_cmd(8'hAF); check_state("R13 pending cleared by reset");

    repeat (3) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7: actual %0d strobes missing expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule